// File: doc/BRIEF.md
# Fly-by Multi-Channel DMA Controller

This block moves words between peripherals and memory on the processor's bus without the words ever passing through it. Software sets up each of four independent channels with a start address, a word count and a direction. When a peripheral raises its request line, the controller asks the processor for the bus, waits for the grant, and then acknowledges the device. On each clock it puts the channel address on the bus and pairs a memory strobe with the opposite I/O strobe, so memory and device exchange the word directly.

After each word the channel address steps up by one and the count steps down by one. When the count reaches zero the controller hands the bus back and raises a completion interrupt. Software clears that interrupt by reading the channel status. If the device drops its request or the processor withdraws its grant partway through, the controller finishes the bus cycle in progress and releases the bus. It keeps the remaining address and count, and picks the block up again later. Only one channel owns the bus at a time. Among waiting channels, the lowest number wins.

Top module: `flyby_dma`

## Requirements
- R1: After reset, busReq, devAck, all four strobes and doneIrq are low, and every channel reads back zero in every field.
- R2: Register port: regAddr[3:2] selects the channel and regAddr[1:0] selects the field: 0 current address, 1 remaining count, 2 mode (bit 0 = 1 for memory-to-device, 0 for device-to-memory), 3 status (bit 0 = block done). Address, count and mode read back what was written.
- R3: busReq rises the cycle after a qualifying request is sampled. devAck and the strobes stay low for as long as busGrant is low. devAck for the served channel rises the cycle after busGrant is sampled high, and the first bus cycle follows one cycle later.
- R4: A memory-to-device word drives busAddr with the channel address and asserts memReadStb together with ioWriteStb, one word per clock.
- R5: A device-to-memory word asserts ioReadStb together with memWriteStb, one word per clock.
- R6: Each word increments the channel address (wrapping modulo the address width) and decrements its count. A block moves exactly the programmed number of words, leaving the address at start plus count and the count at zero.
- R7: In the cycle after the last word, busReq and devAck are low, the channel's done bit is set and doneIrq is high.
- R8: Reading a channel's status returns the done bit and clears it. doneIrq falls when no done bit remains set.
- R9: When several channels request at once, the lowest-numbered channel is served first and finishes its block before a higher one starts.
- R10: If the request drops or the grant is withdrawn mid-block, the controller completes the bus cycle under way, then drops devAck and busReq. The remaining address and count are kept, no strobes occur while the grant is absent, and the block resumes to completion.
- R11: A channel with a count of zero never raises busReq, and a higher-numbered channel with a nonzero count is served instead.
- R12: At most one devAck bit is high at any time, and a strobe is only asserted while busReq and a devAck bit are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write enable |
| regRdEn | input | 1 | Register read enable (clears status on read) |
| regAddr | input | 4 | Channel (bits 3:2) and field (bits 1:0) |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| devReq | input | 4 | Per-channel service request from devices |
| devAck | output | 4 | Per-channel acknowledge to devices |
| busReq | output | 1 | Bus hold request to the processor |
| busGrant | input | 1 | Bus hold grant from the processor |
| busAddr | output | 16 | Memory address during a bus cycle |
| memReadStb | output | 1 | Memory read strobe |
| memWriteStb | output | 1 | Memory write strobe |
| ioReadStb | output | 1 | Device read strobe |
| ioWriteStb | output | 1 | Device write strobe |
| doneIrq | output | 1 | Completion interrupt |

## Verification
The transfer path is driven with a short block whose grant is held back, which separates request timing from acknowledge timing. It is also driven with full blocks in each direction, one of them crossing the top of the address space, which separates the two strobe pairings and shows the address wrapping. Two simultaneous requests expose the arbitration order. A request that drops and a grant that is withdrawn mid-block show whether the remaining address and count survive a pause. A zero-count channel requesting beside a live one tells a disabled channel apart from one that is merely lower in priority.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2,
    ST_XFER = 2'd3
  } dmaState_e;

  // Field select inside a channel's register window
  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_CNT  = 2'd1;
  localparam logic [1:0] FLD_MODE = 2'd2;
  localparam logic [1:0] FLD_STAT = 2'd3;

  // Strobes from the sequencer to the channel datapath
  typedef struct packed {
    logic busCycle;  // one word moves this cycle; step address and count
    logic finish;    // this word is the last one of the block
  } dmaStrobe_t;

endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import flyby_dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [CH_W-1:0]   regCh,
  input  logic [1:0]        regFld,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [CH_W-1:0]   chSel,
  input  dmaStrobe_t        strb,
  output logic [NUM_CH-1:0] cntNonZero,
  output logic              lastWord,
  output logic              selMemToDev,
  output logic [ADDR_W-1:0] selAddr,
  output logic              doneIrq
);

  logic [ADDR_W-1:0] addrQ [NUM_CH];
  logic [CNT_W-1:0]  cntQ  [NUM_CH];
  logic [NUM_CH-1:0] dirQ;
  logic [NUM_CH-1:0] doneQ;

  logic [NUM_CH-1:0] stepHit;
  logic [NUM_CH-1:0] regHit;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      stepHit[c]    = strb.busCycle && (chSel == CH_W'(c));
      regHit[c]     = (regCh == CH_W'(c));
      cntNonZero[c] = (cntQ[c] != '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        addrQ[c] <= '0;
        cntQ[c]  <= '0;
      end
      dirQ  <= '0;
      doneQ <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        // a bus cycle on this channel takes precedence over a register write
        if (stepHit[c]) begin
          addrQ[c] <= addrQ[c] + ADDR_W'(1);
          cntQ[c]  <= cntQ[c] - CNT_W'(1);
        end else if (regWrEn && regHit[c]) begin
          if (regFld == FLD_ADDR) addrQ[c] <= regWrData[ADDR_W-1:0];
          if (regFld == FLD_CNT)  cntQ[c]  <= regWrData[CNT_W-1:0];
        end
        if (regWrEn && regHit[c] && regFld == FLD_MODE) dirQ[c] <= regWrData[0];
        if (stepHit[c] && strb.finish)                  doneQ[c] <= 1'b1;
        else if (regRdEn && regHit[c] && regFld == FLD_STAT) doneQ[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regFld)
      FLD_ADDR: regRdData = REG_W'(addrQ[regCh]);
      FLD_CNT:  regRdData = REG_W'(cntQ[regCh]);
      FLD_MODE: regRdData = REG_W'(dirQ[regCh]);
      default:  regRdData = REG_W'(doneQ[regCh]);
    endcase
  end

  assign lastWord    = (cntQ[chSel] == CNT_W'(1));
  assign selMemToDev = dirQ[chSel];
  assign selAddr     = addrQ[chSel];
  assign doneIrq     = |doneQ;

  // A word is never moved on an exhausted channel
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.busCycle |-> (cntQ[chSel] != '0));

  // Each word advances the address and consumes one count
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.busCycle |=> (cntQ[$past(chSel)] == $past(cntQ[chSel]) - CNT_W'(1))
                   && (addrQ[$past(chSel)] == $past(addrQ[chSel]) + ADDR_W'(1)));

  // Finishing a block raises the interrupt
  assert_done_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busCycle && strb.finish) |=> doneIrq);

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import flyby_dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] devReq,
  input  logic              busGrant,
  input  logic [NUM_CH-1:0] cntNonZero,
  input  logic              lastWord,
  output logic              busReq,
  output logic [NUM_CH-1:0] devAck,
  output logic [CH_W-1:0]   chSel,
  output dmaStrobe_t        strb
);

  dmaState_e         stateQ;
  logic [CH_W-1:0]   chQ;
  logic [NUM_CH-1:0] eligible;
  logic [CH_W-1:0]   pick;
  logic [NUM_CH-1:0] lowMask;

  assign eligible = devReq & cntNonZero;

  // fixed priority: lowest-numbered eligible channel
  always_comb begin
    pick = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (eligible[c]) pick = CH_W'(c);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      chQ    <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (|eligible) begin
          chQ    <= pick;
          stateQ <= ST_REQ;
        end
        ST_REQ: begin
          if (!eligible[chQ])  stateQ <= ST_IDLE;
          else if (busGrant)   stateQ <= ST_ACK;
        end
        ST_ACK:  stateQ <= ST_XFER;
        ST_XFER: begin
          if (lastWord || !busGrant || !devReq[chQ]) stateQ <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busReq        = (stateQ != ST_IDLE);
  assign devAck        = (stateQ == ST_ACK || stateQ == ST_XFER) ? (NUM_CH'(1) << chQ) : '0;
  assign chSel         = chQ;
  assign strb.busCycle = (stateQ == ST_XFER);
  assign strb.finish   = (stateQ == ST_XFER) && lastWord;
  assign lowMask       = (NUM_CH'(1) << chQ) - NUM_CH'(1);

  // Acknowledge only follows a sampled grant
  assert_ack_after_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|devAck) |-> $past(busGrant));

  // Bus handed back right after the final word
  assert_release_after_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (!busReq && devAck == '0));

  // A bus request only starts for a channel that has work
  assert_no_zero_request_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(|(devReq & cntNonZero)));

  // No lower-numbered channel was waiting when this one was chosen
  assert_priority_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && |eligible) |=> (($past(eligible) & lowMask) == '0));

  // Single owner of the bus
  assert_one_ack_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(devAck));

endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
  import flyby_dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RA_W  = CH_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [NUM_CH-1:0] devReq,
  output logic [NUM_CH-1:0] devAck,
  output logic              busReq,
  input  logic              busGrant,
  output logic [ADDR_W-1:0] busAddr,
  output logic              memReadStb,
  output logic              memWriteStb,
  output logic              ioReadStb,
  output logic              ioWriteStb,
  output logic              doneIrq
);

  dmaStrobe_t        strb;
  logic [CH_W-1:0]   chSel;
  logic [NUM_CH-1:0] cntNonZero;
  logic              lastWord;
  logic              selMemToDev;
  logic [ADDR_W-1:0] selAddr;

  dma_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .devReq     (devReq),
    .busGrant   (busGrant),
    .cntNonZero (cntNonZero),
    .lastWord   (lastWord),
    .busReq     (busReq),
    .devAck     (devAck),
    .chSel      (chSel),
    .strb       (strb)
  );

  dma_datapath #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W), .CH_W(CH_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regRdEn     (regRdEn),
    .regCh       (regAddr[RA_W-1:2]),
    .regFld      (regAddr[1:0]),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .chSel       (chSel),
    .strb        (strb),
    .cntNonZero  (cntNonZero),
    .lastWord    (lastWord),
    .selMemToDev (selMemToDev),
    .selAddr     (selAddr),
    .doneIrq     (doneIrq)
  );

  assign busAddr     = strb.busCycle ? selAddr : '0;
  assign memReadStb  = strb.busCycle &&  selMemToDev;
  assign ioWriteStb  = strb.busCycle &&  selMemToDev;
  assign ioReadStb   = strb.busCycle && !selMemToDev;
  assign memWriteStb = strb.busCycle && !selMemToDev;

  // Memory read is always paired with a device write
  assert_pair_m2d_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReadStb |-> (ioWriteStb && !ioReadStb && !memWriteStb));

  // Device read is always paired with a memory write
  assert_pair_d2m_R5: assert property (@(posedge clk) disable iff (!rstN)
    ioReadStb |-> (memWriteStb && !memReadStb && !ioWriteStb));

  // Strobes only while the bus is held and a device is acknowledged
  assert_strobe_owned_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReadStb || memWriteStb || ioReadStb || ioWriteStb) |-> (busReq && devAck != '0));

endmodule

// File: tb/tb_flyby_dma.sv
module tb_flyby_dma;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [3:0]  devReq = '0;
  logic [3:0]  devAck;
  logic        busReq;
  logic        busGrant = 1'b0;
  logic [15:0] busAddr;
  logic        memReadStb, memWriteStb, ioReadStb, ioWriteStb;
  logic        doneIrq;

  logic        grantEn = 1'b1;
  int          nTests = 0;
  int          nFail = 0;

  int          logN = 0;
  int          badN = 0;
  logic [15:0] logAddr [64];
  logic [3:0]  logAck  [64];
  int          logKind [64];

  flyby_dma dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .devReq(devReq), .devAck(devAck),
    .busReq(busReq), .busGrant(busGrant), .busAddr(busAddr),
    .memReadStb(memReadStb), .memWriteStb(memWriteStb),
    .ioReadStb(ioReadStb), .ioWriteStb(ioWriteStb), .doneIrq(doneIrq)
  );

  always #5 clk = ~clk;

  // processor model: grants the bus shortly after each edge while enabled
  initial forever begin
    @(posedge clk);
    #2;
    busGrant = busReq && grantEn;
  end

  // bus monitor: records every word and counts ownership violations
  initial forever begin
    @(negedge clk);
    if (rstN) begin
      if (!$onehot0(devAck)) badN++;
      if (memReadStb || memWriteStb || ioReadStb || ioWriteStb) begin
        if (devAck == 4'd0 || !busReq) badN++;
        if (logN < 64) begin
          logAddr[logN] = busAddr;
          logAck[logN]  = devAck;
          if (memReadStb && ioWriteStb && !memWriteStb && !ioReadStb) logKind[logN] = 1;
          else if (ioReadStb && memWriteStb && !memReadStb && !ioWriteStb) logKind[logN] = 2;
          else logKind[logN] = 0;
        end
        logN++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] ch, input logic [1:0] fld, input logic [15:0] data);
    regAddr   = {ch, fld};
    regWrData = data;
    regWrEn   = 1'b1;
    tick();
    regWrEn   = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ch, input logic [1:0] fld, output logic [15:0] data);
    regAddr = {ch, fld};
    regRdEn = 1'b1;
    #1;
    data = regRdData;
    tick();
    regRdEn = 1'b0;
  endtask

  task automatic setup(input logic [1:0] ch, input logic [15:0] addr, input logic [15:0] cnt, input logic m2d);
    wr(ch, 2'd0, addr);
    wr(ch, 2'd1, cnt);
    wr(ch, 2'd2, {15'd0, m2d});
  endtask

  task automatic doReset();
    devReq  = '0;
    grantEn = 1'b1;
    regWrEn = 1'b0;
    regRdEn = 1'b0;
    rstN    = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    logN = 0;
  endtask

  task automatic waitIrq(input int maxCyc);
    for (int i = 0; i < maxCyc; i++) begin
      if (doneIrq) break;
      tick();
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    doReset();
    chk("R1", "busReq", 32'(busReq), 32'd0);
    chk("R1", "devAck", 32'(devAck), 32'd0);
    chk("R1", "strobes", 32'({memReadStb, memWriteStb, ioReadStb, ioWriteStb}), 32'd0);
    chk("R1", "doneIrq", 32'(doneIrq), 32'd0);
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 4; f++) begin
        rd(2'(c), 2'(f), v);
        chk("R1", "field after reset", 32'(v), 32'd0);
      end
    end
  endtask

  task automatic t_regs();
    logic [15:0] v;
    doReset();
    setup(2'd2, 16'h1234, 16'h0007, 1'b1);
    rd(2'd2, 2'd0, v); chk("R2", "address readback", 32'(v), 32'h1234);
    rd(2'd2, 2'd1, v); chk("R2", "count readback", 32'(v), 32'h0007);
    rd(2'd2, 2'd2, v); chk("R2", "mode readback", 32'(v), 32'h0001);
    rd(2'd1, 2'd0, v); chk("R2", "other channel untouched", 32'(v), 32'h0000);
  endtask

  task automatic t_handshake();
    doReset();
    setup(2'd1, 16'h0040, 16'd2, 1'b1);
    grantEn = 1'b0;
    devReq  = 4'b0010;
    tick();
    chk("R3", "busReq after request", 32'(busReq), 32'd1);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R3", "no devAck without grant", 32'(devAck), 32'd0);
    end
    chk("R3", "no words without grant", 32'(logN), 32'd0);
    grantEn = 1'b1;
    tick();
    chk("R3", "devAck before grant sampled", 32'(devAck), 32'd0);
    tick();
    chk("R3", "devAck after grant", 32'(devAck), 32'b0010);
    chk("R3", "no word in acknowledge cycle", 32'(logN), 32'd0);
    tick();
    chk("R4", "first word", 32'(logN), 32'd1);
    tick();
    chk("R4", "one word per clock", 32'(logN), 32'd2);
    tick();
    chk("R7", "busReq released", 32'(busReq), 32'd0);
    chk("R7", "devAck released", 32'(devAck), 32'd0);
    chk("R7", "doneIrq", 32'(doneIrq), 32'd1);
    chk("R4", "word0 addr", 32'(logAddr[0]), 32'h40);
    chk("R4", "word1 addr", 32'(logAddr[1]), 32'h41);
    chk("R4", "pairing", 32'(logKind[0] + logKind[1]), 32'd2);
    devReq = '0;
  endtask

  task automatic t_block_m2d();
    logic [15:0] v;
    doReset();
    setup(2'd0, 16'h0100, 16'd5, 1'b1);
    devReq = 4'b0001;
    waitIrq(60);
    devReq = '0;
    tick();
    chk("R6", "word total", 32'(logN), 32'd5);
    for (int i = 0; i < 5; i++) begin
      chk("R4", "sequential address", 32'(logAddr[i]), 32'(16'h0100 + 16'(i)));
      chk("R4", "memory read with device write", 32'(logKind[i]), 32'd1);
    end
    rd(2'd0, 2'd0, v); chk("R6", "final address", 32'(v), 32'h0105);
    rd(2'd0, 2'd1, v); chk("R6", "final count", 32'(v), 32'd0);
  endtask

  task automatic t_block_d2m();
    logic [15:0] v;
    doReset();
    setup(2'd3, 16'hFFFE, 16'd3, 1'b0);
    devReq = 4'b1000;
    waitIrq(60);
    devReq = '0;
    tick();
    chk("R6", "word total", 32'(logN), 32'd3);
    chk("R6", "wrap addr0", 32'(logAddr[0]), 32'hFFFE);
    chk("R6", "wrap addr1", 32'(logAddr[1]), 32'hFFFF);
    chk("R6", "wrap addr2", 32'(logAddr[2]), 32'h0000);
    for (int i = 0; i < 3; i++) begin
      chk("R5", "device read with memory write", 32'(logKind[i]), 32'd2);
      chk("R5", "ack on channel 3", 32'(logAck[i]), 32'b1000);
    end
    rd(2'd3, 2'd0, v); chk("R6", "address after wrap", 32'(v), 32'h0001);
  endtask

  task automatic t_status();
    logic [15:0] v;
    chk("R8", "irq pending before read", 32'(doneIrq), 32'd1);
    rd(2'd0, 2'd3, v); chk("R8", "idle channel status", 32'(v), 32'd0);
    chk("R8", "irq kept after other read", 32'(doneIrq), 32'd1);
    rd(2'd3, 2'd3, v); chk("R8", "done bit", 32'(v), 32'd1);
    chk("R8", "irq cleared", 32'(doneIrq), 32'd0);
    rd(2'd3, 2'd3, v); chk("R8", "done bit cleared", 32'(v), 32'd0);
  endtask

  task automatic t_priority();
    doReset();
    setup(2'd0, 16'h0010, 16'd3, 1'b1);
    setup(2'd3, 16'h0030, 16'd2, 1'b1);
    devReq = 4'b1001;
    for (int i = 0; i < 60; i++) begin
      if (logN >= 5) break;
      tick();
    end
    repeat (3) tick();
    devReq = '0;
    chk("R9", "word total", 32'(logN), 32'd5);
    for (int i = 0; i < 3; i++) begin
      chk("R9", "channel 0 first", 32'(logAck[i]), 32'b0001);
      chk("R9", "channel 0 address", 32'(logAddr[i]), 32'(16'h0010 + 16'(i)));
    end
    for (int i = 3; i < 5; i++) begin
      chk("R9", "channel 3 after", 32'(logAck[i]), 32'b1000);
      chk("R9", "channel 3 address", 32'(logAddr[i]), 32'(16'h0030 + 16'(i - 3)));
    end
  endtask

  task automatic t_pause();
    logic [15:0] v;
    int held;
    doReset();
    setup(2'd2, 16'h0200, 16'd6, 1'b0);
    devReq = 4'b0100;
    for (int i = 0; i < 40; i++) begin
      if (logN >= 2) break;
      tick();
    end
    devReq = '0;
    repeat (3) tick();
    chk("R10", "request drop stops after current word", 32'(logN), 32'd2);
    chk("R10", "busReq released", 32'(busReq), 32'd0);
    chk("R10", "devAck released", 32'(devAck), 32'd0);
    rd(2'd2, 2'd1, v); chk("R10", "count kept", 32'(v), 32'd4);
    rd(2'd2, 2'd0, v); chk("R10", "address kept", 32'(v), 32'h0202);
    devReq = 4'b0100;
    for (int i = 0; i < 40; i++) begin
      if (logN >= 4) break;
      tick();
    end
    grantEn = 1'b0;
    repeat (6) tick();
    held = logN;
    repeat (3) tick();
    chk("R10", "no words without grant", 32'(logN), 32'(held));
    chk("R10", "block not finished", 32'(held < 6), 32'd1);
    chk("R10", "re-request while paused", 32'(busReq), 32'd1);
    chk("R10", "no devAck while paused", 32'(devAck), 32'd0);
    rd(2'd2, 2'd1, v); chk("R10", "count matches words", 32'(v), 32'(6 - held));
    grantEn = 1'b1;
    waitIrq(60);
    devReq = '0;
    tick();
    chk("R10", "resumed to completion", 32'(logN), 32'd6);
    for (int i = 0; i < 6; i++) begin
      chk("R10", "address sequence", 32'(logAddr[i]), 32'(16'h0200 + 16'(i)));
    end
    rd(2'd2, 2'd0, v); chk("R10", "final address", 32'(v), 32'h0206);
  endtask

  task automatic t_zero();
    doReset();
    wr(2'd1, 2'd1, 16'd0);
    devReq = 4'b0010;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R11", "zero count never requests", 32'(busReq), 32'd0);
    end
    setup(2'd2, 16'h0500, 16'd1, 1'b1);
    devReq = 4'b0110;
    waitIrq(40);
    devReq = '0;
    tick();
    chk("R11", "live channel served", 32'(logN), 32'd1);
    chk("R11", "served channel is 2", 32'(logAck[0]), 32'b0100);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_handshake();
    t_block_m2d();
    t_block_d2m();
    t_status();
    t_priority();
    t_pause();
    t_zero();
    chk("R12", "ownership violations", 32'(badN), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule